// File: doc/BRIEF.md
# Nibble-Parallel DS3 Transmit Payload Interface

This block sits between terminal equipment and a DS3 transmit framer. It runs entirely on the high-rate transmit input clock and divides that clock by four to produce a nibble clock for the terminal. Each rising edge of the nibble clock captures one 4-bit payload nibble. The block keeps a count of nibble positions within a 1176-nibble DS3 payload frame, and shifts each captured nibble out as serial bits, most significant bit first, one bit per input clock. A marker flags the first serial bit of every frame for the downstream framer.

A one-byte operating-mode register sets the frame timing. A 2-bit timing-select field picks one of two behaviours. In one the block is frame master: a free-running counter sets frame timing, and the block drives a frame-reference pulse for the terminal. In the other the block is frame slave: the terminal's frame reference sets frame timing, and a reference that arrives at the wrong position sets a sticky alignment-error flag. A hold bit in the same register puts the whole datapath into an idle state and clears that flag. The block runs only while the nibble-interface select input is high.

Top module: `nib_tx_payload_if`

## Requirements
- R1: The mode register sits at address 0x00 and comes out of reset as 8'h29. All eight bits are read/write. Bit 4 is the hold bit and bits 1:0 are the timing select. Reads from any other address return 0, and writes to any other address leave the register unchanged.
- R2: While running, nib_clk_o is the input clock divided by 4: high for 2 cycles, then low for 2 cycles. The payload nibble is captured on the input-clock edge at which nib_clk_o rises.
- R3: With timing select not equal to 2'b01 (frame master), captured nibbles are numbered 0 to 1175, wrapping from 1175 to 0, and nibble 0 is the first one captured after running starts. frame_ref_o is high for the whole nibble period that ends with the capture of nibble 0 and low in every other nibble period.
- R4: After each capture, ser_bit_o presents the nibble's bits 3, 2, 1, 0 in that order, one per input clock, starting the cycle after the capture. ser_valid_o is high while these bits are presented.
- R5: ser_first_o is high together with bit 3 of nibble 0 and low with every other serial bit.
- R6: With timing select 2'b01 (frame slave), a nibble captured while frame_ref_i is high becomes nibble 0, and the following nibbles count on from 1. frame_ref_o stays low in this mode.
- R7: In slave mode, if frame_ref_i is high at a capture whose expected position is not 0, align_err_o goes high and stays high until the hold bit is set. Setting the hold bit clears it.
- R8: In master mode frame_ref_i has no effect: it does not move the frame position and it does not set align_err_o.
- R9: While the hold bit is set or nib_mode_i is low, nib_clk_o, ser_valid_o, ser_first_o and frame_ref_o are low and the frame position returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Transmit input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| nib_mode_i | input | 1 | Nibble-interface select; high enables the block |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| nib_clk_o | output | 1 | Nibble clock (input clock divided by 4) |
| nib_data_i | input | NIB_W | Payload nibble from terminal |
| frame_ref_i | input | 1 | External frame reference (slave mode) |
| frame_ref_o | output | 1 | Generated frame reference (master mode) |
| ser_bit_o | output | 1 | Serial payload bit |
| ser_valid_o | output | 1 | Serial bit valid |
| ser_first_o | output | 1 | First bit of a frame |
| align_err_o | output | 1 | Sticky frame-alignment error |

## Verification
The properties assume that the terminal holds nib_data_i and frame_ref_i steady for a whole nibble period. They also assume that register writes are single-cycle strobes on input-clock edges. The bench therefore changes payload and reference only on the falling input-clock edge right after a nibble-clock rise, and pulses the write strobe for exactly one cycle. Start and stop points are placed so that no nibble is cut off mid-serialisation. Nibble-interface select is dropped only after the last expected bit has been presented.

// File: rtl/nibtx_pkg.sv
package nibtx_pkg;
  localparam logic [7:0] MODE_RST_VAL = 8'h29;
  localparam logic [1:0] TREF_SLAVE   = 2'b01;
  localparam int         HOLD_BIT     = 4;
endpackage

// File: rtl/nibtx_mode_reg.sv
module nibtx_mode_reg #(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              hold_o,
  output logic [1:0]        tref_o
);
  import nibtx_pkg::*;

  logic [7:0] mode_q, mode_d;
  logic       sel;

  assign sel = (addr_i == '0);

  always_comb begin
    mode_d = mode_q;
    if (wr_i && sel) mode_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_RST_VAL;
    else         mode_q <= mode_d;
  end

  assign rdata_o = sel ? mode_q : 8'h00;
  assign hold_o  = mode_q[HOLD_BIT];
  assign tref_o  = mode_q[1:0];
endmodule

// File: rtl/nibtx_clk_div.sv
module nibtx_clk_div #(
  parameter int DIV_LOG2 = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic nib_clk_o,
  output logic cap_o
);
  localparam int               DIV    = 1 << DIV_LOG2;
  localparam logic [DIV_LOG2-1:0] CAP_PH = DIV_LOG2'(DIV / 2 - 1);

  logic [DIV_LOG2-1:0] ph_q, ph_d;

  always_comb begin
    if (run_i) ph_d = ph_q + 1'b1;
    else       ph_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= '0;
    else         ph_q <= ph_d;
  end

  assign nib_clk_o = ph_q[DIV_LOG2-1];
  assign cap_o     = run_i && (ph_q == CAP_PH);
endmodule

// File: rtl/nibtx_frame_ctr.sv
module nibtx_frame_ctr #(
  parameter int FRAME_NIBS = 1176
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic cap_i,
  input  logic slave_i,
  input  logic ext_ref_i,
  input  logic clr_err_i,
  output logic first_o,
  output logic frame_ref_o,
  output logic align_err_o
);
  localparam int               CNT_W = $clog2(FRAME_NIBS);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(FRAME_NIBS - 1);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             err_q, err_d;
  logic             ext_hit, at_zero;

  assign at_zero = (cnt_q == '0);
  assign ext_hit = cap_i && slave_i && ext_ref_i;

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)        cnt_d = '0;
    else if (ext_hit)  cnt_d = ONE;
    else if (cap_i)    cnt_d = (cnt_q == LAST) ? '0 : cnt_q + ONE;
  end

  always_comb begin
    err_d = err_q;
    if (clr_err_i)                 err_d = 1'b0;
    else if (ext_hit && !at_zero)  err_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end

  assign first_o     = cap_i && (ext_hit || at_zero);
  assign frame_ref_o = run_i && !slave_i && at_zero;
  assign align_err_o = err_q;
endmodule

// File: rtl/nibtx_serializer.sv
module nibtx_serializer #(
  parameter int NIB_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [NIB_W-1:0] nib_i,
  input  logic             first_i,
  output logic             bit_o,
  output logic             valid_o,
  output logic             first_o
);
  logic [NIB_W-1:0] sh_q, sh_d;
  logic             val_q, val_d;
  logic             fst_q, fst_d;

  always_comb begin
    sh_d  = {sh_q[NIB_W-2:0], 1'b0};
    val_d = val_q;
    fst_d = 1'b0;
    if (!run_i) begin
      sh_d  = '0;
      val_d = 1'b0;
    end else if (load_i) begin
      sh_d  = nib_i;
      val_d = 1'b1;
      fst_d = first_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      val_q <= 1'b0;
      fst_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      val_q <= val_d;
      fst_q <= fst_d;
    end
  end

  assign bit_o   = sh_q[NIB_W-1];
  assign valid_o = val_q;
  assign first_o = fst_q;
endmodule

// File: rtl/nib_tx_payload_if.sv
module nib_tx_payload_if #(
  parameter int ADDR_W     = 4,
  parameter int NIB_W      = 4,
  parameter int FRAME_NIBS = 1176
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              nib_mode_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              nib_clk_o,
  input  logic [NIB_W-1:0]  nib_data_i,
  input  logic              frame_ref_i,
  output logic              frame_ref_o,
  output logic              ser_bit_o,
  output logic              ser_valid_o,
  output logic              ser_first_o,
  output logic              align_err_o
);
  import nibtx_pkg::*;

  localparam int DIV_LOG2 = $clog2(NIB_W);

  logic       hold, run, slave, cap, first;
  logic [1:0] tref;

  nibtx_mode_reg #(.ADDR_W(ADDR_W)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .hold_o  (hold),
    .tref_o  (tref)
  );

  assign run   = nib_mode_i && !hold;
  assign slave = (tref == TREF_SLAVE);

  nibtx_clk_div #(.DIV_LOG2(DIV_LOG2)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .nib_clk_o (nib_clk_o),
    .cap_o     (cap)
  );

  nibtx_frame_ctr #(.FRAME_NIBS(FRAME_NIBS)) u_ctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .cap_i       (cap),
    .slave_i     (slave),
    .ext_ref_i   (frame_ref_i),
    .clr_err_i   (hold),
    .first_o     (first),
    .frame_ref_o (frame_ref_o),
    .align_err_o (align_err_o)
  );

  nibtx_serializer #(.NIB_W(NIB_W)) u_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .load_i  (cap),
    .nib_i   (nib_data_i),
    .first_i (first),
    .bit_o   (ser_bit_o),
    .valid_o (ser_valid_o),
    .first_o (ser_first_o)
  );
endmodule

// File: rtl/nibtx_checker.sv
module nibtx_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic run,
  input logic slave,
  input logic hold,
  input logic nib_clk_o,
  input logic frame_ref_o,
  input logic ser_valid_o,
  input logic ser_first_o,
  input logic align_err_o
);
  p_clk_only_running_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nib_clk_o) |-> $past(run));

  p_ref_master_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_ref_o |-> (run && !slave));

  p_first_with_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_first_o |-> ser_valid_o);

  p_err_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (align_err_o && !hold) |=> align_err_o);

  p_err_cleared_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold |=> !align_err_o);

  p_master_no_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!slave && !align_err_o) |=> !align_err_o);

  p_idle_outputs_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> (!nib_clk_o && !ser_valid_o && !ser_first_o));
endmodule

bind nib_tx_payload_if nibtx_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .run         (run),
  .slave       (slave),
  .hold        (hold),
  .nib_clk_o   (nib_clk_o),
  .frame_ref_o (frame_ref_o),
  .ser_valid_o (ser_valid_o),
  .ser_first_o (ser_first_o),
  .align_err_o (align_err_o)
);

// File: tb/nib_tx_payload_if_tb_top.sv
module nib_tx_payload_if_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME      = 1176;
  localparam int ADDR_W     = 4;

  logic              clk_i = 1'b0;
  logic              rst_ni;
  logic              nib_mode_i;
  logic              reg_wr_i;
  logic [ADDR_W-1:0] reg_addr_i;
  logic [7:0]        reg_wdata_i;
  logic [7:0]        reg_rdata_o;
  logic              nib_clk_o;
  logic [3:0]        nib_data_i;
  logic              frame_ref_i;
  logic              frame_ref_o;
  logic              ser_bit_o, ser_valid_o, ser_first_o, align_err_o;

  nib_tx_payload_if #(.ADDR_W(ADDR_W), .NIB_W(4), .FRAME_NIBS(FRAME)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .nib_mode_i(nib_mode_i),
    .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .nib_clk_o(nib_clk_o), .nib_data_i(nib_data_i),
    .frame_ref_i(frame_ref_i), .frame_ref_o(frame_ref_o), .ser_bit_o(ser_bit_o),
    .ser_valid_o(ser_valid_o), .ser_first_o(ser_first_o), .align_err_o(align_err_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 0;
  bit         mon_en = 0;
  int         m = 0;
  bit         exp_err = 0;
  logic [1:0] exp_q[$];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  // scoreboard monitor: R4 bit order, R5 first marker
  always @(negedge clk_i) begin
    if (mon_en && ser_valid_o) begin
      if (exp_q.size() == 0) begin
        check("R4 unexpected serial bit", 32'(ser_valid_o), 32'd0);
      end else begin
        logic [1:0] e;
        e = exp_q.pop_front();
        check("R4/R5 serial bit+first", 32'({ser_bit_o, ser_first_o}), 32'(e));
      end
    end
  end

  task automatic reg_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0; reg_addr_i = '0;
  endtask

  // driver: one nibble per nibble period, expectations pushed into the queue
  task automatic drive_nibbles(input int n, input bit slave_mode, input int ref_a, input int ref_b);
    for (int k = 0; k < n; k++) begin
      logic [3:0] nib;
      bit         r;
      int         idx;
      nib = 4'($urandom);
      r   = (k == ref_a) || (k == ref_b);
      nib_data_i  = nib;
      frame_ref_i = r;
      if (slave_mode && r) begin
        if (m != 0) exp_err = 1;
        idx = 0;
        m   = 1;
      end else begin
        idx = m;
        m   = (m + 1) % FRAME;
      end
      #1;
      if (slave_mode) check("R6 frame_ref_o low in slave", 32'(frame_ref_o), 32'd0);
      else            check("R3 frame_ref_o per nibble", 32'(frame_ref_o), 32'(idx == 0));
      for (int b = 3; b >= 0; b--) exp_q.push_back({nib[b], (b == 3) && (idx == 0)});
      @(posedge nib_clk_o);
      @(negedge clk_i);
    end
    frame_ref_i = 1'b0;
  endtask

  task automatic end_run();
    repeat (3) @(negedge clk_i);
    nib_mode_i = 1'b0;
    m = 0;
    repeat (2) @(negedge clk_i);
    check("R4 all expected bits emitted", 32'(exp_q.size()), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    time t0, t1, t2;
    rst_ni = 1'b0; nib_mode_i = 1'b0; reg_wr_i = 1'b0; reg_addr_i = '0;
    reg_wdata_i = '0; nib_data_i = '0; frame_ref_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state and register access
    check("R1 reset value", 32'(reg_rdata_o), 32'h29);
    check("R9 nib_clk idle", 32'(nib_clk_o), 32'd0);
    check("R9 valid idle", 32'(ser_valid_o), 32'd0);
    check("R9 frame_ref idle", 32'(frame_ref_o), 32'd0);
    check("R7 no error at reset", 32'(align_err_o), 32'd0);
    reg_addr_i = 4'd3; #1;
    check("R1 other address reads 0", 32'(reg_rdata_o), 32'd0);
    @(negedge clk_i);
    reg_write(4'd0, 8'hC6);
    #1 check("R1 readback", 32'(reg_rdata_o), 32'hC6);
    @(negedge clk_i);
    reg_write(4'd5, 8'hFF);
    #1 check("R1 other address write ignored", 32'(reg_rdata_o), 32'hC6);
    @(negedge clk_i);
    reg_write(4'd0, 8'h28); // master, hold clear

    // R2 divider
    nib_mode_i = 1'b1;
    @(posedge nib_clk_o); t0 = $time;
    @(negedge nib_clk_o); t1 = $time;
    @(posedge nib_clk_o); t2 = $time;
    check("R2 nib_clk high time", 32'(t1 - t0), 32'(2 * CLK_PERIOD));
    check("R2 nib_clk period", 32'(t2 - t0), 32'(4 * CLK_PERIOD));
    @(negedge clk_i);
    nib_mode_i = 1'b0;
    repeat (2) @(negedge clk_i);
    check("R9 nib_clk low when deselected", 32'(nib_clk_o), 32'd0);
    check("R9 valid low when deselected", 32'(ser_valid_o), 32'd0);

    // R3/R4/R5/R8 master run over two frame wraps, stray references ignored
    mon_en = 1; m = 0;
    nib_mode_i = 1'b1;
    drive_nibbles(2 * FRAME + 5, 1'b0, 100, 1500);
    end_run();
    check("R8 no error in master", 32'(align_err_o), 32'd0);

    // R6 slave with aligned references
    reg_write(4'd0, 8'h29);
    m = 0; exp_err = 0;
    nib_mode_i = 1'b1;
    drive_nibbles(FRAME + 300, 1'b1, 0, FRAME);
    check("R6 aligned refs no error", 32'(align_err_o), 32'(exp_err));
    // R7 misaligned reference realigns the frame and sets the flag
    drive_nibbles(1500, 1'b1, 400, -1);
    end_run();
    check("R7 error set", 32'(align_err_o), 32'd1);
    repeat (4) @(negedge clk_i);
    check("R7 error sticky", 32'(align_err_o), 32'd1);

    // R9 hold bit idles the datapath, R7 clears the flag
    reg_write(4'd0, 8'h38);
    nib_mode_i = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      check("R9 nib_clk held", 32'(nib_clk_o), 32'd0);
      check("R9 frame_ref held", 32'(frame_ref_o), 32'd0);
      check("R9 valid held", 32'(ser_valid_o), 32'd0);
    end
    check("R7 error cleared by hold", 32'(align_err_o), 32'd0);
    reg_write(4'd0, 8'h28);
    m = 0;
    drive_nibbles(10, 1'b0, -1, -1); // frame restarts at nibble 0
    end_run();
    check("R7 error stays clear", 32'(align_err_o), 32'd0);

    finish_run();
  end
endmodule